// File: doc/BRIEF.md
# Synchronous Burst Static Memory

A single-port synchronous memory with a 32-bit word split into four byte lanes. The storage depth is a parameter. Every control, address and write-data input is sampled on the rising clock edge. A transfer begins when one of two start strobes is sampled. The processor-side strobe always begins a read. The controller-side strobe begins a read or a write, depending on the write inputs. After the start, a 2-bit burst counter supplies the following addresses. It steps once per cycle while the advance input is low and holds while it is high. The wrap order is either linear or interleaved.

Reads are flow-through. The word at the registered address appears on `q` in the cycle after the sampling edge. Writes are self-timed: the data and lane mask are captured with the address and committed at the next edge. There is no tri-state bus. The block presents `q` together with a drive-qualifier `q_drive`, which stands for the output driver. An asynchronous output enable gates only that qualifier. A sleep request puts the block into a low-power idle state after a fixed count of sampled cycles and brings it out again after the same count. Memory contents are kept across sleep.

Top module: `sbs_sram`

## Requirements
- R1: The block is selected when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. An accepted start strobe sampled while any of these three conditions fails ends the burst, and `q_drive` is 0 from the next cycle until a new start.
- R2: With `sel0_n`=0, a sampled `cpu_start_n`=0 while selected loads `addr` and makes the cycle a read, whatever the write inputs are.
- R3: While `sel0_n`=1, `cpu_start_n` has no effect, and an active burst continues or holds as R6 describes.
- R4: A sampled `ctl_start_n`=0 while selected (with `cpu_start_n` high or ignored) loads `addr`. The cycle is a write if the write condition holds, otherwise a read.
- R5: Write condition and lanes. `wr_all_n`=0 writes all four lanes. Otherwise `wr_en_n`=0 writes each lane i whose `lane_wr_n[i]`=0, where lane i is bits 8i+7:8i (lane 0 = bits 7:0). `wr_en_n`=1, or no lane enabled, means a read.
- R6: With both strobes sampled high and a burst active, `step_n`=0 advances the burst counter and `step_n`=1 holds it. The cycle is a read or a write according to R5. With no burst active, such a cycle does nothing.
- R7: Only the two lowest address bits change during a burst, and they wrap within a group of four. Let k be the number of advances since the load, taken modulo 4. With `ilv_mode`=0 the low bits are (start+k) mod 4. With `ilv_mode`=1 they are start XOR k.
- R8: Read data for a cycle appears on `q` in the cycle after the sampling edge. A write is committed at the following edge and is visible to a read sampled at that edge.
- R9: `q_drive`=1 exactly when the current cycle is a read of an active burst, `oe_n`=0 and the block is awake. After a write cycle `q_drive` stays 0 until a read cycle.
- R10: `oe_n` acts combinationally on `q_drive`, with no clock edge needed.
- R11: Entering and leaving sleep:
  - `in_sleep` rises after 4 consecutive sampled edges with `sleep_req`=1, and falls after 4 consecutive sampled edges with `sleep_req`=0.
  - While asleep, start strobes are ignored, the burst ends and `q_drive`=0.
  - Memory contents are kept.
- R12: After reset `q_drive`=0, `in_sleep`=0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel0_n | input | 1 | Primary select, active low; also gates the processor strobe |
| sel1 | input | 1 | Second select, active high |
| sel2_n | input | 1 | Third select, active low |
| cpu_start_n | input | 1 | Processor-side start strobe, active low, always a read |
| ctl_start_n | input | 1 | Controller-side start strobe, active low |
| step_n | input | 1 | Burst advance, active low; high holds the address |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_en_n | input | 1 | Lane-write enable, active low |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| addr | input | AW | Start address (AW = log2 DEPTH) |
| wdata | input | 32 | Write data |
| ilv_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Sleep request |
| q | output | 32 | Flow-through read data |
| q_drive | output | 1 | Output-drive qualifier for `q` |
| in_sleep | output | 1 | Block is in the low-power state |

## Verification
Each result is due at a fixed point relative to the edge that samples its stimulus:
- read data and `q_drive` belong to the cycle right after that edge;
- a write becomes visible one edge later;
- `in_sleep` changes on the fourth edge;
- the `oe_n` effect needs no edge.

The bench drives inputs one time unit after each rising edge and updates its behavioural model at that edge. It then compares `q_drive`, `in_sleep` and, when a read is due, `q` one unit later, in the same cycle. The asynchronous enable is compared mid-cycle with no edge in between.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  parameter int unsigned LANES = 4;
  parameter int unsigned DW    = 8 * LANES;

  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_e;

  // Low two address bits of a burst beat: base plus k (linear) or base XOR k (interleaved).
  function automatic logic [1:0] burst_low(input logic [1:0] base, input logic [1:0] k,
                                           input logic ilv);
    return ilv ? (base ^ k) : (base + k);
  endfunction

  // Active-high lane mask from the write inputs; zero means a read.
  function automatic logic [LANES-1:0] lane_mask(input logic all_n, input logic en_n,
                                                 input logic [LANES-1:0] lanes_n);
    if (!all_n)     return '1;
    else if (!en_n) return ~lanes_n;
    else            return '0;
  endfunction
endpackage

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] ld_addr,
  input  logic          ilv,
  output logic [AW-1:0] addr
);
  logic [AW-3:0] hi_q;
  logic [1:0]    base_q;
  logic [1:0]    k_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      k_q    <= '0;
    end else if (load) begin
      hi_q   <= ld_addr[AW-1:2];
      base_q <= ld_addr[1:0];
      k_q    <= '0;
    end else if (step) begin
      k_q <= k_q + 2'd1;
    end
  end

  assign addr = {hi_q, sbs_pkg::burst_low(base_q, k_q, ilv)};
endmodule

// File: rtl/sbs_sleep_seq.sv
module sbs_sleep_seq #(
  parameter int unsigned N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic asleep
);
  localparam int unsigned CW = (N > 2) ? $clog2(N) : 1;

  logic [CW-1:0] cnt_q;
  logic          mism;

  assign mism = req ^ asleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      asleep <= 1'b0;
    end else if (mism) begin
      if (cnt_q == CW'(N - 1)) begin
        asleep <= ~asleep;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             asleep,
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             cpu_start_n,
  input  logic             ctl_start_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             wr_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [DW-1:0]    wdata,
  output logic             load,
  output logic             step,
  output logic             ev_wr_next,
  output logic             cur_rd,
  output logic             cur_wr,
  output logic [LANES-1:0] wr_mask,
  output logic [DW-1:0]    wr_data
);
  op_e              op_q, op_d;
  logic             selected, cpu_hit;
  logic [LANES-1:0] mask_now;
  logic             wcond;

  assign selected = !sel0_n && sel1 && !sel2_n;
  assign cpu_hit  = !cpu_start_n && !sel0_n;
  assign mask_now = lane_mask(wr_all_n, wr_en_n, lane_wr_n);
  assign wcond    = |mask_now;

  always_comb begin
    op_d = op_q;
    load = 1'b0;
    step = 1'b0;
    if (asleep) begin
      op_d = OP_IDLE;
    end else if (cpu_hit) begin
      load = selected;
      op_d = selected ? OP_RD : OP_IDLE;
    end else if (!ctl_start_n) begin
      load = selected;
      op_d = !selected ? OP_IDLE : (wcond ? OP_WR : OP_RD);
    end else if (op_q != OP_IDLE) begin
      step = !step_n;
      op_d = wcond ? OP_WR : OP_RD;
    end
  end

  assign ev_wr_next = (op_d == OP_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      wr_mask <= '0;
      wr_data <= '0;
    end else begin
      op_q <= op_d;
      if (ev_wr_next) begin
        wr_mask <= mask_now;
        wr_data <= wdata;
      end
    end
  end

  assign cur_rd = (op_q == OP_RD);
  assign cur_wr = (op_q == OP_WR);
endmodule

// File: rtl/sbs_array.sv
module sbs_array
  import sbs_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] mask,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && mask[l]) mem[addr] <= wdata[8*l +: 8];
    end
    assign rdata[8*l +: 8] = mem[addr];
  end
endmodule

// File: rtl/sbs_sram.sv
module sbs_sram
  import sbs_pkg::*;
#(
  parameter int unsigned DEPTH     = 256,
  parameter int unsigned SLEEP_CYC = 4,
  localparam int unsigned AW       = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             cpu_start_n,
  input  logic             ctl_start_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             wr_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             ilv_mode,
  input  logic             oe_n,
  input  logic             sleep_req,
  output logic [DW-1:0]    q,
  output logic             q_drive,
  output logic             in_sleep
);
  logic             load, step, ev_wr_next, cur_rd, cur_wr;
  logic [LANES-1:0] wr_mask;
  logic [DW-1:0]    wr_data;
  logic [AW-1:0]    cur_addr;
  logic             asleep;

  sbs_sleep_seq #(.N(SLEEP_CYC)) u_sleep (
    .clk(clk), .rst_n(rst_n), .req(sleep_req), .asleep(asleep)
  );

  sbs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .asleep(asleep),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_en_n(wr_en_n), .lane_wr_n(lane_wr_n), .wdata(wdata),
    .load(load), .step(step), .ev_wr_next(ev_wr_next),
    .cur_rd(cur_rd), .cur_wr(cur_wr), .wr_mask(wr_mask), .wr_data(wr_data)
  );

  sbs_burst_ctr #(.AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .ld_addr(addr), .ilv(ilv_mode), .addr(cur_addr)
  );

  sbs_array #(.AW(AW)) u_mem (
    .clk(clk), .we(cur_wr), .addr(cur_addr), .mask(wr_mask),
    .wdata(wr_data), .rdata(q)
  );

  assign q_drive  = cur_rd && !oe_n && !asleep;
  assign in_sleep = asleep;
endmodule

// File: rtl/sbs_sram_chk.sv
module sbs_sram_chk
  import sbs_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          sel0_n,
  input logic          sel1,
  input logic          sel2_n,
  input logic          cpu_start_n,
  input logic          ctl_start_n,
  input logic          step_n,
  input logic          oe_n,
  input logic          sleep_req,
  input logic [DW-1:0] q,
  input logic          q_drive,
  input logic          in_sleep,
  input logic          ev_wr_next
);
  logic sel_ok;
  assign sel_ok = !sel0_n && sel1 && !sel2_n;

  // R1: an accepted strobe while not selected turns the drive off
  a_r1_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sleep && ((!cpu_start_n && !sel0_n) || !ctl_start_n) && !sel_ok) |=> !q_drive);

  // R2: a processor strobe while selected begins a read
  a_r2_cpu_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sleep && !cpu_start_n && sel_ok) |=> (q_drive == (!oe_n && !in_sleep)));

  // R3: a processor strobe with sel0_n high leaves a held read burst untouched
  a_r3_cpu_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sleep && sel0_n && !cpu_start_n && ctl_start_n && step_n && q_drive && !ev_wr_next)
    |=> $stable(q));

  // R6: a held read burst keeps its data
  a_r6_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_start_n && ctl_start_n && step_n && q_drive && !ev_wr_next) |=> $stable(q));

  // R9: a write cycle never drives the output
  a_r9_off_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_next |=> !q_drive);

  // R10: output enable high blocks the drive
  a_r10_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !q_drive);

  // R11: asleep means no drive, and sleep is only entered under request
  a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_sleep |-> !q_drive);
  a_r11_entry_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sleep) |-> $past(sleep_req));
endmodule

bind sbs_sram sbs_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
  .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .step_n(step_n),
  .oe_n(oe_n), .sleep_req(sleep_req), .q(q), .q_drive(q_drive),
  .in_sleep(in_sleep), .ev_wr_next(ev_wr_next)
);

// File: tb/sbs_sram_tb.sv
`timescale 1ns/1ps
module sbs_sram_tb;
  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel0_n, sel1, sel2_n, cpu_start_n, ctl_start_n, step_n;
  logic wr_all_n, wr_en_n, ilv_mode, oe_n, sleep_req;
  logic [3:0]    lane_wr_n;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic [31:0]   q;
  logic          q_drive, in_sleep;

  always #5 clk = ~clk;

  sbs_sram #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_en_n(wr_en_n), .lane_wr_n(lane_wr_n), .addr(addr),
    .wdata(wdata), .ilv_mode(ilv_mode), .oe_n(oe_n), .sleep_req(sleep_req),
    .q(q), .q_drive(q_drive), .in_sleep(in_sleep)
  );

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R12";
  bit    done = 0;

  // Behavioural reference model
  logic [31:0] ref_mem [DEPTH];
  bit          m_active, m_wr, m_sleep;
  int          m_hi, m_base, m_k, m_scnt;
  logic [3:0]  m_mask;
  logic [31:0] m_data;

  function automatic int m_addr();
    int lo;
    if (ilv_mode) lo = m_base ^ m_k;
    else          lo = (m_base + m_k) % 4;
    return m_hi * 4 + lo;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit sel, was_sleep, wc;
      logic [3:0] mk;
      if (m_wr) begin
        for (int l = 0; l < 4; l++)
          if (m_mask[l]) ref_mem[m_addr()][8*l +: 8] = m_data[8*l +: 8];
      end
      was_sleep = m_sleep;
      if (sleep_req != m_sleep) begin
        m_scnt++;
        if (m_scnt == 4) begin m_sleep = !m_sleep; m_scnt = 0; end
      end else m_scnt = 0;
      sel = (sel0_n == 0) && (sel1 == 1) && (sel2_n == 0);
      if (wr_all_n == 0)     mk = 4'hF;
      else if (wr_en_n == 0) mk = ~lane_wr_n;
      else                   mk = 4'h0;
      wc = (mk != 0);
      if (was_sleep) begin
        m_active = 0; m_wr = 0;
      end else if (cpu_start_n == 0 && sel0_n == 0) begin
        if (sel) begin
          m_active = 1; m_wr = 0; m_hi = int'(addr) / 4; m_base = int'(addr) % 4; m_k = 0;
        end else begin m_active = 0; m_wr = 0; end
      end else if (ctl_start_n == 0) begin
        if (sel) begin
          m_active = 1; m_wr = wc; m_hi = int'(addr) / 4; m_base = int'(addr) % 4; m_k = 0;
        end else begin m_active = 0; m_wr = 0; end
      end else if (m_active) begin
        if (step_n == 0) m_k = (m_k + 1) % 4;
        m_wr = wc;
      end
      if (m_wr && !was_sleep) begin m_mask = mk; m_data = wdata; end
    end
  end

  task automatic compare();
    bit exp_drv;
    exp_drv = m_active && !m_wr && !oe_n && !m_sleep;
    n_cmp++;
    if (q_drive !== exp_drv) begin
      n_bad++;
      $display("FAIL %s q_drive actual=%0b expected=%0b t=%0t", cur_req, q_drive, exp_drv, $time);
    end
    n_cmp++;
    if (in_sleep !== m_sleep) begin
      n_bad++;
      $display("FAIL %s in_sleep actual=%0b expected=%0b t=%0t", cur_req, in_sleep, m_sleep, $time);
    end
    if (exp_drv) begin
      n_cmp++;
      if (q !== ref_mem[m_addr()]) begin
        n_bad++;
        $display("FAIL %s q actual=%h expected=%h t=%0t", cur_req, q, ref_mem[m_addr()], $time);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic idle();
    sel0_n = 0; sel1 = 1; sel2_n = 0; cpu_start_n = 1; ctl_start_n = 1; step_n = 1;
    wr_all_n = 1; wr_en_n = 1; lane_wr_n = 4'hF; wdata = '0;
  endtask

  function automatic logic [31:0] pat(int a);
    return {8'(a), 8'(~a), 8'(a * 3 + 1), 8'h5A};
  endfunction

  task automatic read_burst(int a, int steps);
    cpu_start_n = 0; addr = AW'(a); tick(); cpu_start_n = 1;
    for (int j = 0; j < steps; j++) begin step_n = 0; tick(); end
    step_n = 1;
  endtask

  initial begin
    idle(); addr = '0; ilv_mode = 0; oe_n = 0; sleep_req = 0;
    m_active = 0; m_wr = 0; m_sleep = 0; m_scnt = 0; m_hi = 0; m_base = 0; m_k = 0;
    m_mask = 0; m_data = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cur_req = "R12"; compare();

    // R4/R5: fill words 0..31 with full-lane writes via the controller strobe
    cur_req = "R4";
    for (int b = 0; b < 8; b++) begin
      ctl_start_n = 0; wr_all_n = 0; addr = AW'(b * 4); wdata = pat(b * 4); tick();
      ctl_start_n = 1;
      for (int j = 1; j < 4; j++) begin step_n = 0; wdata = pat(b * 4 + j); tick(); end
      step_n = 1; wr_all_n = 1;
    end
    tick();

    // R7/R8: linear order, every start offset
    cur_req = "R7"; ilv_mode = 0;
    for (int off = 0; off < 4; off++) read_burst(8 + off, 4);
    // R7: interleaved order, every start offset
    cur_req = "R7"; ilv_mode = 1;
    for (int off = 0; off < 4; off++) read_burst(16 + off, 4);
    ilv_mode = 0;

    // R6: suspend holds the address, then resumes
    cur_req = "R6";
    cpu_start_n = 0; addr = 8'd21; tick(); cpu_start_n = 1;
    step_n = 1; tick(); tick();
    step_n = 0; tick(); step_n = 1; tick();

    // R10: output enable acts without a clock edge
    cur_req = "R10";
    oe_n = 1; #1 compare();
    oe_n = 0; #1 compare();

    // R5: masked write to lanes 0 and 2, then read back
    cur_req = "R5";
    ctl_start_n = 0; wr_en_n = 0; lane_wr_n = 4'b1010; addr = 8'd5; wdata = 32'hDEADBEEF; tick();
    ctl_start_n = 1; wr_en_n = 1; lane_wr_n = 4'hF; tick();
    read_burst(5, 1);
    // R5: wr_en_n low but no lane selected is a read
    ctl_start_n = 0; wr_en_n = 0; lane_wr_n = 4'hF; addr = 8'd6; tick();
    ctl_start_n = 1; wr_en_n = 1; tick();

    // R9/R8: write drives nothing, following read sees the new data
    cur_req = "R9";
    ctl_start_n = 0; wr_all_n = 0; addr = 8'd12; wdata = 32'h13572468; tick();
    ctl_start_n = 1; wr_all_n = 1; tick();
    cur_req = "R8";
    step_n = 0; wr_all_n = 0; wdata = 32'hCAFEF00D; tick();
    wr_all_n = 1; step_n = 1; tick();
    read_burst(12, 3);

    // R2: write inputs ignored on a processor-strobe start
    cur_req = "R2";
    cpu_start_n = 0; wr_all_n = 0; addr = 8'd3; wdata = 32'hFFFF0000; tick();
    cpu_start_n = 1; wr_all_n = 1; tick();
    read_burst(3, 0);

    // R3: processor strobe ignored while sel0_n high; burst goes on
    cur_req = "R3";
    read_burst(24, 1);
    sel0_n = 1; cpu_start_n = 0; addr = 8'd0; tick();
    step_n = 0; tick(); step_n = 1; cpu_start_n = 1; tick();
    sel0_n = 0;

    // R1: deselect through each select input
    cur_req = "R1";
    read_burst(9, 0);
    sel1 = 0; ctl_start_n = 0; tick(); ctl_start_n = 1; sel1 = 1; tick();
    read_burst(9, 0);
    sel2_n = 1; cpu_start_n = 0; tick(); cpu_start_n = 1; sel2_n = 0; tick();
    read_burst(9, 0);
    sel0_n = 1; ctl_start_n = 0; tick(); ctl_start_n = 1; sel0_n = 0; tick();
    step_n = 0; tick(); step_n = 1;

    // R11: sleep entry, ignored strobes, wake, contents kept
    cur_req = "R11";
    read_burst(2, 0);
    sleep_req = 1;
    repeat (4) tick();
    cpu_start_n = 0; addr = 8'd7; tick(); cpu_start_n = 1;
    ctl_start_n = 0; wr_all_n = 0; addr = 8'd7; wdata = 32'h0; tick();
    ctl_start_n = 1; wr_all_n = 1;
    sleep_req = 0;
    repeat (4) tick();
    read_burst(4, 3);
    // short pulse does not enter sleep
    sleep_req = 1; repeat (2) tick(); sleep_req = 0; repeat (3) tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule